// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial bus target (I2C, standard and fast mode) that holds a small bank of byte-wide control registers and returns a set of status bytes to the bus master. SCL and SDA arrive asynchronously. Each line passes through a two-flop synchroniser and then a glitch filter that runs on the system clock. START and STOP are recognised as SDA edges while the filtered SCL is high.

A write transaction carries the device address, then a register index, then any number of data bytes. The index advances after every stored byte and returns to zero after the last register. A read transaction returns the status bytes in ascending order for as long as the master acknowledges. The target releases SDA once the master refuses a byte. The lowest address bit comes from a strap input, so two of these targets can share one bus. The all-zero general call address gets no response.

The SDA output is a pull-down enable. The pad drives the line low while it is 1 and leaves the line to the bus pull-up while it is 0.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1011010 with the last of those seven bits replaced by `addr_lsb`. For writes this gives address byte B4h when `addr_lsb`=0 and B6h when it is 1. Bit 0 of the address byte selects read (1) or write (0).
- R2: An address byte with any other upper seven bits, including the general call value 00h, is not acknowledged. The rest of that transaction changes no register.
- R3: In a write, the byte after the address is the register index. The byte after that is stored in register `index`, which appears on `ctrl_q[index*8 +: 8]`. Every byte is acknowledged.
- R4: Each further data byte in the same write goes to the next register index.
- R5: After a byte is stored at index NREG-1 (04h by default), the next data byte goes to index 0.
- R6: A register index above NREG-1 is not acknowledged. The data bytes that follow in that transaction are neither acknowledged nor stored.
- R7: In a read, byte k is `stat_bytes[k*8 +: 8]`, sent MSB first, starting at k=0 for every read. Each master ACK advances k, and k returns to 0 after RD_BYTES-1.
- R8: After the master NACKs a read byte, `sda_pull` stays 0 until the next START. `sda_pull` never changes while the filtered SCL stays high.
- R9: A pulse on SCL or SDA shorter than FILT system clocks is ignored. It neither adds a bit nor creates a START or STOP.
- R10: After reset `sda_pull` is 0 and every register reads 00h.
- R11: A repeated START in the middle of a transaction restarts the address phase. The new transaction is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and filtering |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_lsb | input | 1 | Strap that sets the lowest device address bit |
| stat_bytes | input | RD_BYTES*8 | Status bytes returned by reads, byte k at bits k*8+7..k*8 |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_q | output | NREG*8 | Control register bank, register i at bits i*8+7..i*8 |

## Verification
The bench builds the target with the default five registers, FILT=2 and RD_BYTES=3. The three-byte status bank lets a four-byte read reach the wrap of the read pointer back to byte 0. The two-cycle filter lets a single-cycle spike on SDA during SCL high, or on SCL during SCL low, test spike rejection inside a real data byte without slowing the bus model. With five registers, an index of 05h is the first illegal value, and a four-byte write starting at index 2 crosses the wrap from the last register to register 0.

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave #(
  parameter int          NREG     = 5,
  parameter int          RD_BYTES = 2,
  parameter int          FILT     = 3,
  parameter logic [5:0]  ADDR_HI  = 6'b101101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_lsb,
  input  logic [RD_BYTES*8-1:0] stat_bytes,
  output logic                  sda_pull,
  output logic [NREG*8-1:0]     ctrl_q
);
  localparam int LAST_SUB = NREG - 1;
  localparam int SPW      = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int RPW      = (RD_BYTES > 1) ? $clog2(RD_BYTES) : 1;
  localparam int FW       = $clog2(FILT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WDAT, S_ACK, S_RDAT, S_RACK, S_SKIP} st_t;

  logic [1:0]    s_scl, s_sda;
  logic [FW-1:0] c_scl, c_sda;
  logic          f_scl, f_sda, scl_q, sda_q;
  logic          scl_rise, scl_fall, start, stop;

  st_t             st, nxt;
  logic [3:0]      bitcnt;
  logic [7:0]      sh, tx;
  logic [SPW-1:0]  sub;
  logic [RPW-1:0]  rptr;
  logic            mack;
  logic [7:0]      regs [NREG];
  logic [7:0]      cur_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_scl <= 2'b11; s_sda <= 2'b11;
      c_scl <= '0;    c_sda <= '0;
      f_scl <= 1'b1;  f_sda <= 1'b1;
      scl_q <= 1'b1;  sda_q <= 1'b1;
    end else begin
      s_scl <= {s_scl[0], scl_i};
      s_sda <= {s_sda[0], sda_i};
      scl_q <= f_scl;
      sda_q <= f_sda;
      if (s_scl[1] == f_scl) c_scl <= '0;
      else if (c_scl == FW'(FILT - 1)) begin f_scl <= s_scl[1]; c_scl <= '0; end
      else c_scl <= c_scl + 1'b1;
      if (s_sda[1] == f_sda) c_sda <= '0;
      else if (c_sda == FW'(FILT - 1)) begin f_sda <= s_sda[1]; c_sda <= '0; end
      else c_sda <= c_sda + 1'b1;
    end
  end

  assign scl_rise = f_scl & ~scl_q;
  assign scl_fall = ~f_scl & scl_q;
  assign start    = f_scl & scl_q & sda_q & ~f_sda;
  assign stop     = f_scl & scl_q & ~sda_q & f_sda;
  assign cur_byte = stat_bytes[int'(rptr)*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE;
      bitcnt <= '0; sh <= '0; tx <= '0;
      sub <= '0; rptr <= '0; mack <= 1'b0;
      sda_pull <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start) begin
      st <= S_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_pull <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_SUB, S_WDAT: begin
          if (scl_rise && bitcnt < 4'd8) begin
            sh <= {sh[6:0], f_sda};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            st <= S_SKIP;
            if (st == S_ADDR) begin
              if (sh[7:1] == {ADDR_HI, addr_lsb}) begin
                sda_pull <= 1'b1; st <= S_ACK; rptr <= '0;
                nxt <= sh[0] ? S_RDAT : S_SUB;
              end
            end else if (st == S_SUB) begin
              if (sh <= 8'(LAST_SUB)) begin
                sub <= SPW'(sh); sda_pull <= 1'b1; st <= S_ACK; nxt <= S_WDAT;
              end
            end else begin
              regs[sub] <= sh;
              sub <= (sub == SPW'(LAST_SUB)) ? '0 : sub + 1'b1;
              sda_pull <= 1'b1; st <= S_ACK; nxt <= S_WDAT;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          bitcnt <= '0;
          st <= nxt;
          if (nxt == S_RDAT) begin
            tx <= cur_byte; sda_pull <= ~cur_byte[7];
          end else sda_pull <= 1'b0;
        end
        S_RDAT: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0; st <= S_RACK;
            end else begin
              sda_pull <= ~tx[6]; tx <= {tx[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~f_sda;
            if (!f_sda) rptr <= (rptr == RPW'(RD_BYTES - 1)) ? '0 : rptr + 1'b1;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              tx <= cur_byte; sda_pull <= ~cur_byte[7]; st <= S_RDAT;
            end else begin
              sda_pull <= 1'b0; st <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign ctrl_q[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2c_ctl_slave_chk.sv
module i2c_ctl_slave_chk #(
  parameter int NREG = 5,
  parameter int SPW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              f_scl,
  input logic              s_scl,
  input logic              sda_oe,
  input logic              start,
  input logic              stop,
  input logic [SPW-1:0]    sub,
  input logic [NREG*8-1:0] ctrl_q
);
  a_r1_pull_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !f_scl);

  a_r8_quiet_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (f_scl && $past(f_scl) && !$past(start) && !$past(stop)) |-> $stable(sda_oe));

  a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (f_scl != $past(f_scl)) |-> (f_scl == $past(s_scl)));

  a_r5_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= SPW'(NREG - 1));

  a_r3_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> !$past(f_scl));
endmodule

bind i2c_ctl_slave i2c_ctl_slave_chk #(.NREG(NREG), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .f_scl(f_scl), .s_scl(s_scl[1]), .sda_oe(sda_pull),
  .start(start), .stop(stop), .sub(sub), .ctrl_q(ctrl_q)
);

// File: tb/sim_i2c_ctl_slave.sv
module sim_i2c_ctl_slave;
  localparam int NREG = 5, RDB = 3, FILT = 2, Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_lsb = 1'b0;
  logic [RDB*8-1:0] stat = 24'h3C5AA5;
  logic sda_pull;
  logic [NREG*8-1:0] ctrl_q;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_ctl_slave #(.NREG(NREG), .RD_BYTES(RDB), .FILT(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_lsb(addr_lsb),
    .stat_bytes(stat), .sda_pull(sda_pull), .ctrl_q(ctrl_q));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] er [NREG];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(ctrl_q[i*8 +: 8]), 32'(er[i]));
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbit(input logic b, input bit g);
    sda_m = b; wq(Q); scl_m = 1'b1;
    if (g) begin wq(4); sda_m = ~b; wq(1); sda_m = b; wq(2*Q-5); end
    else wq(2*Q);
    scl_m = 1'b0;
    if (g) begin wq(3); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q-4); end
    else wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit g, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i], g && i == 2);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input bit ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    end
    wbit(ack_it ? 1'b0 : 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R10 pull after reset", 32'(sda_pull), 32'd0);
    chk("R10 regs after reset", 32'(ctrl_q), 32'd0);
  endtask

  task automatic t_addr();
    logic a;
    addr_lsb = 1'b0;
    i2c_start(); wbyte(8'hB4, 0, a); chk("R1 B4 ack", 32'(a), 32'd1);
    wbyte(8'h00, 0, a); chk("R3 index ack", 32'(a), 32'd1);
    wbyte(8'hA1, 0, a); chk("R3 data ack", 32'(a), 32'd1);
    i2c_stop(); er[0] = 8'hA1; chk_regs("R3 stored");
    addr_lsb = 1'b1;
    i2c_start(); wbyte(8'hB4, 0, a); chk("R2 B4 with strap 1", 32'(a), 32'd0); i2c_stop();
    i2c_start(); wbyte(8'hB6, 0, a); chk("R1 B6 ack", 32'(a), 32'd1);
    wbyte(8'h01, 0, a); wbyte(8'hC7, 0, a); i2c_stop(); er[1] = 8'hC7; chk_regs("R1 B6 write");
    i2c_start(); wbyte(8'h00, 0, a); chk("R2 general call", 32'(a), 32'd0);
    wbyte(8'h01, 0, a); chk("R2 no ack after miss", 32'(a), 32'd0);
    wbyte(8'hEE, 0, a); i2c_stop(); chk_regs("R2 regs unchanged");
    addr_lsb = 1'b0;
  endtask

  task automatic t_multi();
    logic a;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    i2c_start(); wbyte(8'hB4, 0, a); wbyte(8'h02, 0, a);
    for (int i = 0; i < 4; i++) begin
      wbyte(d[i], 0, a); chk("R4 burst ack", 32'(a), 32'd1);
    end
    i2c_stop();
    er[2] = 8'h11; er[3] = 8'h22; er[4] = 8'h33; er[0] = 8'h44;
    chk_regs("R4 R5 increment and wrap");
  endtask

  task automatic t_badsub();
    logic a;
    i2c_start(); wbyte(8'hB4, 0, a); wbyte(8'h05, 0, a); chk("R6 index 05 nack", 32'(a), 32'd0);
    wbyte(8'h99, 0, a); chk("R6 data nack", 32'(a), 32'd0); i2c_stop();
    i2c_start(); wbyte(8'hB4, 0, a); wbyte(8'hFF, 0, a); chk("R6 index FF nack", 32'(a), 32'd0);
    wbyte(8'h98, 0, a); i2c_stop();
    chk_regs("R6 regs unchanged");
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    i2c_start(); wbyte(8'hB5, 0, a); chk("R7 read addr ack", 32'(a), 32'd1);
    rbyte(1, b); chk("R7 byte0", 32'(b), 32'hA5);
    rbyte(1, b); chk("R7 byte1", 32'(b), 32'h5A);
    rbyte(1, b); chk("R7 byte2", 32'(b), 32'h3C);
    rbyte(0, b); chk("R7 wrap to byte0", 32'(b), 32'hA5);
    chk("R8 released after nack", 32'(sda_pull), 32'd0);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    chk("R8 released next clock", 32'(sda_pull), 32'd0);
    scl_m = 1'b0; wq(Q);
    i2c_stop(); chk("R8 released after stop", 32'(sda_pull), 32'd0);
    i2c_start(); wbyte(8'hB5, 0, a); rbyte(0, b); chk("R7 restart at byte0", 32'(b), 32'hA5);
    i2c_stop();
  endtask

  task automatic t_restart();
    logic a;
    i2c_start(); wbyte(8'hB4, 0, a); wbyte(8'h01, 0, a);
    i2c_start(); wbyte(8'hB4, 0, a); chk("R11 addr after restart", 32'(a), 32'd1);
    wbyte(8'h03, 0, a); wbyte(8'h5A, 0, a); chk("R11 data ack", 32'(a), 32'd1);
    i2c_stop(); er[3] = 8'h5A; chk_regs("R11 restart write");
  endtask

  task automatic t_glitch();
    logic a;
    i2c_start(); wbyte(8'hB4, 0, a); wbyte(8'h01, 0, a);
    wbyte(8'h77, 1, a); chk("R9 ack with spikes", 32'(a), 32'd1);
    i2c_stop(); er[1] = 8'h77; chk_regs("R9 spikes ignored");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) er[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_addr();
    t_multi();
    t_badsub();
    t_read();
    t_restart();
    t_glitch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule